// File: doc/BRIEF.md
# Serial Sampling Converter Frame Controller

This block is the digital control for a 12-bit serial sampling converter. An active-low chip select and an external serial clock come in asynchronously. Both are synchronised into a free-running system clock, and their edges are detected there. A chip-select falling edge freezes the sample and starts a 16-bit frame. The frame is four zero bits followed by the 12-bit result, most significant bit first, and it is shifted out on the falling edges of the serial clock. The result itself arrives on a parallel port that stands in for the analog core. A data-enable output takes the place of a three-state driver.

The number of serial-clock falling edges seen before chip select rises selects the power state, so no command register is needed:
- Rising very early is treated as a glitch.
- Rising inside a middle window powers the block down.
- Rising late only aborts the conversion.

From power-down, only a frame that stays low past the tenth falling edge wakes the block. After a wake-up, a ready flag stays low for a programmable number of system clocks. Every frame is tagged with whether its data can be trusted. Each input change takes effect at the outputs on the third system-clock edge after it.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After synchronous reset, sdo_en=0, hold=0, powered=1 (1 means normal mode) and ready=1.
- R2: A chip-select falling edge sets sdo_en=1 and hold=1 (1 means sample frozen).
- R3: The frame word is {4'b0000, conv_data} captured at the chip-select fall. Bit 15 is on sdo at the chip-select fall, and bit 15-k after the k-th serial-clock fall, for k = 1..15.
- R4: On the 16th serial-clock fall, sdo_en returns to 0. A chip-select rise at any point also clears sdo_en.
- R5: In a normal frame, hold stays 1 through the 13th fall and returns to 0 on the serial-clock rise that follows it.
- R6: When the block is powered and chip select rises after fewer than 2 falls, powered stays 1.
- R7: When the block is powered and chip select rises after 2 to 9 falls, powered becomes 0.
- R8: When the block is powered and chip select rises after 10 or more falls, powered stays 1 and the frame is aborted.
- R9: In power-down, a frame that ends with fewer than 10 falls leaves powered=0. A frame that ends with 10 or more falls sets powered=1.
- R10: In a frame begun during power-down, hold returns to 0 on the first serial-clock edge after the chip-select fall.
- R11: ready is 0 whenever powered=0. After a wake-up, ready stays 0 for PWRUP_CYCLES system clocks and then becomes 1.
- R12: result_ok takes the value of ready at each chip-select fall and holds it for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous active-low chip select |
| sclk | input | 1 | Asynchronous serial clock, idles high |
| conv_data | input | DATA_W | Conversion result from the core |
| sdo | output | 1 | Serial data out, forced to 0 while disabled |
| sdo_en | output | 1 | Data driver enable |
| hold | output | 1 | 1 = sample frozen, 0 = tracking |
| powered | output | 1 | 1 = normal mode, 0 = power-down |
| ready | output | 1 | Powered and power-up delay elapsed |
| result_ok | output | 1 | Current frame's data is valid |

## Verification
Some relations are checked on every cycle:
- ready is never high in power-down, and it is low on the cycle the block wakes.
- A frame always starts with hold set and a zero bit.
- Dropping into power-down always coincides with the data driver being released.
- result_ok at frame start matches ready.

Other behaviour can only be shown by the bench's scenarios:
- the exact bit order;
- the edge-count boundaries at 2 and 10;
- the track-return point after the 13th edge and the early return in a wake frame;
- the length of the power-up delay.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic {
        PWR_ON   = 1'b0,
        PWR_DOWN = 1'b1
    } pwr_e;

    // Edge counts that decide the power state and the track return point
    localparam int GUARD_EDGE = 2;
    localparam int AWAKE_EDGE = 10;
    localparam int TRACK_EDGE = 13;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sclk_fall;
        logic sclk_rise;
    } evt_t;

    function automatic pwr_e next_pwr(input pwr_e cur, input int unsigned falls);
        if (cur == PWR_ON)
            return (falls >= GUARD_EDGE && falls < AWAKE_EDGE) ? PWR_DOWN : PWR_ON;
        else
            return (falls >= AWAKE_EDGE) ? PWR_ON : PWR_DOWN;
    endfunction

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-1:0], din[i]};
        end
        assign rise[i] =  pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[i] = ~pipe[STAGES-1] &  pipe[STAGES];
    end
endmodule

// File: rtl/sar_pwrup_timer.sv
module sar_pwrup_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic powered,
    input  logic start,
    output logic ready
);
    localparam int W = $clog2(CYCLES + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= W'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign ready = powered & (cnt == '0) & ~start;
endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              ev,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              ready_in,
    output logic              sdo,
    output logic              sdo_en,
    output logic              hold,
    output logic              powered,
    output logic              wake_pulse,
    output logic              result_ok
);
    localparam int FRAME_LEN = DATA_W + LEAD_ZEROS;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TRK_CNT  = CNT_W'(TRACK_EDGE);

    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     cnt;
    logic                 active;
    logic                 wake_frame;
    pwr_e                 pwr, pwr_nxt;

    always_comb pwr_nxt = next_pwr(pwr, 32'(cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            cnt        <= '0;
            active     <= 1'b0;
            wake_frame <= 1'b0;
            sdo_en     <= 1'b0;
            hold       <= 1'b0;
            pwr        <= PWR_ON;
            wake_pulse <= 1'b0;
            result_ok  <= 1'b0;
        end else begin
            wake_pulse <= 1'b0;
            if (ev.cs_fall) begin
                active     <= 1'b1;
                cnt        <= '0;
                shreg      <= {{LEAD_ZEROS{1'b0}}, conv_data};
                sdo_en     <= 1'b1;
                hold       <= 1'b1;
                wake_frame <= (pwr == PWR_DOWN);
                result_ok  <= ready_in;
            end else if (ev.cs_rise) begin
                active <= 1'b0;
                sdo_en <= 1'b0;
                hold   <= 1'b0;
                if (active) begin
                    pwr        <= pwr_nxt;
                    wake_pulse <= (pwr == PWR_DOWN) && (pwr_nxt == PWR_ON);
                end
            end else if (active) begin
                if (ev.sclk_fall && cnt != FULL_CNT) begin
                    cnt   <= cnt + 1'b1;
                    shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
                    if (cnt == LAST_CNT) sdo_en <= 1'b0;
                end
                if (wake_frame && (ev.sclk_fall || ev.sclk_rise)) hold <= 1'b0;
                if (ev.sclk_rise && cnt >= TRK_CNT) hold <= 1'b0;
            end
        end
    end

    assign sdo     = sdo_en & shreg[FRAME_LEN-1];
    assign powered = (pwr == PWR_ON);
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int LEAD_ZEROS   = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int PWRUP_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sdo,
    output logic              sdo_en,
    output logic              hold,
    output logic              powered,
    output logic              ready,
    output logic              result_ok
);
    logic [1:0] rise_v, fall_v;
    logic       wake_pulse;
    evt_t       ev;

    sar_edge_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cs_n, sclk}),
        .rise (rise_v),
        .fall (fall_v)
    );

    always_comb begin
        ev.cs_fall   = fall_v[1];
        ev.cs_rise   = rise_v[1];
        ev.sclk_fall = fall_v[0];
        ev.sclk_rise = rise_v[0];
    end

    sar_frame_seq #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .conv_data  (conv_data),
        .ready_in   (ready),
        .sdo        (sdo),
        .sdo_en     (sdo_en),
        .hold       (hold),
        .powered    (powered),
        .wake_pulse (wake_pulse),
        .result_ok  (result_ok)
    );

    sar_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .powered (powered),
        .start   (wake_pulse),
        .ready   (ready)
    );
endmodule

// File: rtl/sar_serial_ctrl_chk.sv
module sar_serial_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sdo,
    input logic sdo_en,
    input logic hold,
    input logic powered,
    input logic ready,
    input logic result_ok
);
    assert_start_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> hold);

    assert_first_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> !sdo);

    assert_down_releases_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(powered) |-> $fell(sdo_en));

    assert_down_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        !powered |-> !ready);

    assert_wake_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(powered) |-> !ready);

    assert_ok_from_ready_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> (result_ok == $past(ready)));
endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk u_chk (.*);

// File: tb/sar_serial_ctrl_tb.sv
module sar_serial_ctrl_tb;
    localparam int PWRUP = 50;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, cs_n, sclk;
    logic [11:0] conv_data;
    logic        sdo, sdo_en, hold, powered, ready, result_ok;
    int          n_run = 0;
    int          n_fail = 0;

    sar_serial_ctrl #(.PWRUP_CYCLES(PWRUP)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .conv_data(conv_data),
        .sdo(sdo), .sdo_en(sdo_en), .hold(hold), .powered(powered),
        .ready(ready), .result_ok(result_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drop_cs();  cs_n = 1'b0; wait_clk(4); endtask
    task automatic raise_cs(); cs_n = 1'b1; wait_clk(4); endtask
    task automatic fall_sclk(); sclk = 1'b0; wait_clk(4); endtask
    task automatic rise_sclk(); sclk = 1'b1; wait_clk(4); endtask

    // One frame with nf serial-clock falls; normal=0 for a frame begun in power-down
    task automatic run_frame(input logic [11:0] d, input int nf, input bit normal);
        logic [15:0] w;
        w = {4'b0000, d};
        conv_data = d;
        drop_cs();
        chk("R2 sdo_en at frame start", sdo_en, 1);
        chk("R2 hold at frame start", hold, 1);
        chk("R3 first leading zero", sdo, 0);
        for (int k = 1; k <= nf; k++) begin
            fall_sclk();
            if (k < 16) chk("R3 frame bit", sdo, w[15-k]);
            else        chk("R4 release at 16th fall", sdo_en, 0);
            if (normal && k == 13) chk("R5 hold through 13th fall", hold, 1);
            if (!normal && k == 1) chk("R10 wake frame tracks early", hold, 0);
            rise_sclk();
            if (normal && k == 12) chk("R5 hold before 13th", hold, 1);
            if (normal && k == 13) chk("R5 track after 13th", hold, 0);
        end
        raise_cs();
        chk("R4 released after cs rise", sdo_en, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b1; conv_data = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        chk("R1 sdo_en", sdo_en, 0);
        chk("R1 hold", hold, 0);
        chk("R1 powered", powered, 1);
        chk("R1 ready", ready, 1);
    endtask

    task automatic t_full_frames();
        run_frame(12'hA5C, 16, 1);
        chk("R12 ok when ready", result_ok, 1);
        chk("R8 powered after full frame", powered, 1);
        run_frame(12'h5A3, 16, 1);
        run_frame(12'hFFF, 16, 1);
        run_frame(12'h001, 16, 1);
        chk("R12 ok when ready", result_ok, 1);
    endtask

    task automatic t_glitch();
        run_frame(12'h123, 0, 1);
        chk("R6 zero falls stays powered", powered, 1);
        run_frame(12'h123, 1, 1);
        chk("R6 one fall stays powered", powered, 1);
        chk("R6 ready kept", ready, 1);
    endtask

    task automatic t_late_abort();
        run_frame(12'h456, 10, 1);
        chk("R8 ten falls stays powered", powered, 1);
        run_frame(12'h456, 11, 1);
        chk("R8 eleven falls stays powered", powered, 1);
        chk("R8 ready kept", ready, 1);
    endtask

    task automatic t_power_cycle();
        run_frame(12'h789, 2, 1);
        chk("R7 two falls powers down", powered, 0);
        chk("R11 not ready when down", ready, 0);
        run_frame(12'h321, 9, 0);
        chk("R9 nine falls stays down", powered, 0);
        chk("R12 invalid in power-down", result_ok, 0);
        run_frame(12'h321, 10, 0);
        chk("R9 ten falls wakes", powered, 1);
        chk("R11 not ready right after wake", ready, 0);
        run_frame(12'h654, 0, 1);
        chk("R12 frame before ready invalid", result_ok, 0);
        chk("R11 still not ready", ready, 0);
        wait_clk(PWRUP + 5);
        chk("R11 ready after delay", ready, 1);
        run_frame(12'hC3A, 16, 1);
        chk("R12 valid after ready", result_ok, 1);
        run_frame(12'h0F0, 9, 1);
        chk("R7 nine falls powers down", powered, 0);
        run_frame(12'h0F0, 16, 0);
        chk("R9 full frame wakes", powered, 1);
        wait_clk(PWRUP + 5);
        chk("R11 ready after second wake", ready, 1);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_full_frames();
        t_glitch();
        t_late_abort();
        t_power_cycle();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule